// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer that software reaches over a small 32-bit register bus. A 16-bit counter counts upward from a value that software loads. It advances by one on every tick of a selectable prescaler. When the counter passes its top value, the block sets a sticky overflow flag and emits a one-cycle reset request to the system reset logic. A timeout of N prescaled ticks is obtained by loading 65536 - N. Loading 0xFFFF while the timer runs forces a reset on the next tick.

Every write must carry a register-specific key in its upper bits. A write whose key is wrong is dropped and has no effect. After an accepted write, a busy flag stays up for a fixed number of clocks. This models the time the write needs to cross into the counting domain, and software polls the flag before it enables the timer. The overflow flag survives the reset that the block itself requests. Software can therefore read it afterwards to learn whether the last reset came from the watchdog.

Top module: `kwdt_top`

## Requirements
- R1: A write to byte offset 0 is accepted only when write data bits 31:16 equal 0x5A5A. The counter then takes bits 15:0. Reading offset 0 returns the counter in bits 15:0, with zeros above.
- R2: A write to offset 4 (control A) or offset 8 (control B) is accepted only when bits 31:8 equal 0xA5A5A5. The value is taken from bits 7:0.
  - Control A reads back as: bit 7 enable, bit 5 busy, bit 4 overflow flag, bits 2:0 prescaler select. All its other bits read 0.
  - Control B reads back the 8 bits last written to it.
- R3: A write with a wrong key changes no register and does not raise the busy flag.
- R4: Select codes 0 to 7 choose divisors 1, 4, 16, 32, 64, 128, 1024 and 4096. While enabled, the counter rises once every D clocks. The first increment comes D clocks after the enable write or after a counter load.
- R5: While enable is 0, the counter holds its value.
- R6: A tick at count 0xFFFF has three effects at once: the counter becomes 0, the overflow flag is set, and the reset output goes high for exactly one cycle.
- R7: The overflow flag is sticky. An accepted control A write with bit 4 = 1 leaves it unchanged. An accepted control A write with bit 4 = 0 clears it. The reset input also clears it.
- R8: The busy flag reads 1 for exactly 3 clocks after each accepted write and reads 0 otherwise.
- R9: After reset, the counter, control A and control B all read 0, and the reset output is low.
- R10: Loading 0xFFFF while enabled causes an overflow on the next prescaled tick, D clocks after the load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| bus_addr | input | 4 | Register byte offset |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data including key |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| wdt_rst_o | output | 1 | One-cycle reset request on overflow |

## Verification
A wrong prescaler phase shows up at the counter readback within one divisor period. It appears as an increment one clock early or late, and this is why the checks sample at D-1, D and 3D clocks. A broken key compare shows at once: the counter or control B reads back a changed value the cycle after a bad write, or the busy bit is raised. Errors in the overflow flag or the pulse show in the one cycle around the wrap. There the counter reads 0, bit 4 must read 1 and the reset output must be high for that single cycle only.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int unsigned CNT_W   = 16;
  localparam int unsigned PRE_W   = 12;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned BUS_W   = 32;

  localparam logic [15:0] CNT_KEY = 16'h5A5A;
  localparam logic [23:0] CTL_KEY = 24'hA5A5A5;

  localparam int unsigned OFF_CNT  = 0;
  localparam int unsigned OFF_CTLA = 4;
  localparam int unsigned OFF_CTLB = 8;

  localparam int unsigned BIT_EN   = 7;
  localparam int unsigned BIT_BUSY = 5;
  localparam int unsigned BIT_OVF  = 4;

  function automatic logic [PRE_W-1:0] div_mask(input logic [SEL_W-1:0] sel);
    logic [PRE_W-1:0] m;
    case (sel)
      3'd0:    m = 12'd0;
      3'd1:    m = 12'd3;
      3'd2:    m = 12'd15;
      3'd3:    m = 12'd31;
      3'd4:    m = 12'd63;
      3'd5:    m = 12'd127;
      3'd6:    m = 12'd1023;
      default: m = 12'd4095;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/kwdt_keygate.sv
module kwdt_keygate
  import kwdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic              wr_cnt,
  output logic              wr_ctla,
  output logic              wr_ctlb,
  output logic [CNT_W-1:0]  cnt_val,
  output logic [BYTE_W-1:0] ctl_val
);
  logic cnt_key_ok;
  logic ctl_key_ok;

  always_comb begin
    cnt_key_ok = (wdata[BUS_W-1:CNT_W] == CNT_KEY);
    ctl_key_ok = (wdata[BUS_W-1:BYTE_W] == CTL_KEY);
    wr_cnt  = wr_en && cnt_key_ok && (addr == ADDR_W'(OFF_CNT));
    wr_ctla = wr_en && ctl_key_ok && (addr == ADDR_W'(OFF_CTLA));
    wr_ctlb = wr_en && ctl_key_ok && (addr == ADDR_W'(OFF_CTLB));
    cnt_val = wdata[CNT_W-1:0];
    ctl_val = wdata[BYTE_W-1:0];
  end
endmodule

// File: rtl/kwdt_prescaler.sv
module kwdt_prescaler
  import kwdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;
  logic [PRE_W-1:0] mask;

  always_comb begin
    mask  = div_mask(sel);
    tick  = run && ((pre_q & mask) == mask);
    pre_d = pre_q;
    if (!run || restart) begin
      pre_d = '0;
    end else begin
      pre_d = pre_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_d;
    end
  end
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter
  import kwdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    wrap   = tick && !load && (cnt_q == {CNT_W{1'b1}});
    cnt_en = load || tick;
    cnt_d  = load ? load_val : (cnt_q + CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/kwdt_busy.sv
module kwdt_busy #(
  parameter int unsigned HOLD = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int unsigned HW = $clog2(HOLD + 1);
  logic [HW-1:0] left_q;
  logic [HW-1:0] left_d;

  always_comb begin
    left_d = left_q;
    if (start) begin
      left_d = HW'(HOLD);
    end else if (left_q != '0) begin
      left_d = left_q - HW'(1);
    end
    busy = (left_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else begin
      left_q <= left_d;
    end
  end
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned BUSY_HOLD = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              wdt_rst_o
);
  logic              wr_cnt, wr_ctla, wr_ctlb, acc_wr;
  logic [CNT_W-1:0]  cnt_val, cnt_q;
  logic [BYTE_W-1:0] ctl_val;
  logic              tick, wrap, busy;

  logic              en_q, en_d;
  logic [SEL_W-1:0]  sel_q, sel_d;
  logic              ovf_q, ovf_d;
  logic [BYTE_W-1:0] ctlb_q, ctlb_d;
  logic              pulse_q;
  logic [BYTE_W-1:0] ctla_rd;

  kwdt_keygate #(.ADDR_W(ADDR_W)) keygate_i (
    .wr_en(bus_wr_en), .addr(bus_addr), .wdata(bus_wdata),
    .wr_cnt(wr_cnt), .wr_ctla(wr_ctla), .wr_ctlb(wr_ctlb),
    .cnt_val(cnt_val), .ctl_val(ctl_val)
  );

  kwdt_prescaler prescaler_i (
    .clk(clk), .rst_n(rst_n), .run(en_q), .restart(wr_cnt),
    .sel(sel_q), .tick(tick)
  );

  kwdt_counter counter_i (
    .clk(clk), .rst_n(rst_n), .load(wr_cnt), .load_val(cnt_val),
    .tick(tick), .cnt_q(cnt_q), .wrap(wrap)
  );

  assign acc_wr = wr_cnt || wr_ctla || wr_ctlb;

  kwdt_busy #(.HOLD(BUSY_HOLD)) busy_i (
    .clk(clk), .rst_n(rst_n), .start(acc_wr), .busy(busy)
  );

  always_comb begin
    en_d   = en_q;
    sel_d  = sel_q;
    ctlb_d = ctlb_q;
    ovf_d  = ovf_q;
    if (wr_ctla) begin
      en_d  = ctl_val[BIT_EN];
      sel_d = ctl_val[SEL_W-1:0];
      if (!ctl_val[BIT_OVF]) begin
        ovf_d = 1'b0;
      end
    end
    if (wrap) begin
      ovf_d = 1'b1;
    end
    if (wr_ctlb) begin
      ctlb_d = ctl_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      sel_q   <= '0;
      ovf_q   <= 1'b0;
      ctlb_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      en_q    <= en_d;
      sel_q   <= sel_d;
      ovf_q   <= ovf_d;
      ctlb_q  <= ctlb_d;
      pulse_q <= wrap;
    end
  end

  always_comb begin
    ctla_rd                = '0;
    ctla_rd[BIT_EN]        = en_q;
    ctla_rd[BIT_BUSY]      = busy;
    ctla_rd[BIT_OVF]       = ovf_q;
    ctla_rd[SEL_W-1:0]     = sel_q;
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFF_CNT)) begin
      bus_rdata = BUS_W'(cnt_q);
    end else if (bus_addr == ADDR_W'(OFF_CTLA)) begin
      bus_rdata = BUS_W'(ctla_rd);
    end else if (bus_addr == ADDR_W'(OFF_CTLB)) begin
      bus_rdata = BUS_W'(ctlb_q);
    end
  end

  assign wdt_rst_o = pulse_q;
endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker
  import kwdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr_en,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic              wdt_rst_o,
  input logic              wr_cnt,
  input logic              acc_wr,
  input logic              en_q,
  input logic              ovf_q,
  input logic              busy,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [BYTE_W-1:0] ctlb_q
);
  assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> cnt_q == $past(bus_wdata[CNT_W-1:0]));

  assert_badkey_ctlb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == ADDR_W'(OFF_CTLB) &&
     bus_wdata[BUS_W-1:BYTE_W] != CTL_KEY) |=> $stable(ctlb_q));

  assert_hold_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wr_cnt) |=> $stable(cnt_q));

  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_o |=> !wdt_rst_o);

  assert_pulse_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_o |-> (ovf_q && cnt_q == '0));

  assert_flag_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> wdt_rst_o);

  assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr |=> busy);

  assert_busy_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(busy, 3) && !$past(acc_wr)));
endmodule

bind kwdt_top kwdt_checker #(.ADDR_W(ADDR_W)) checker_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
  .bus_wdata(bus_wdata), .wdt_rst_o(wdt_rst_o), .wr_cnt(wr_cnt),
  .acc_wr(acc_wr), .en_q(en_q), .ovf_q(ovf_q), .busy(busy),
  .cnt_q(cnt_q), .ctlb_q(ctlb_q)
);

// File: tb/kwdt_top_tb_top.sv
module kwdt_top_tb_top;
  logic        clk;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic        bus_wr_en;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        wdt_rst_o;

  int checks = 0;
  int errors = 0;

  kwdt_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_rst_o(wdt_rst_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] cnt_word(input logic [15:0] v);
    return {16'h5A5A, v};
  endfunction
  function automatic logic [31:0] ctl_word(input logic [7:0] v);
    return {24'hA5A5A5, v};
  endfunction
  function automatic logic [31:0] ctla_exp(input logic en, input logic bsy,
                                           input logic ovf, input logic [2:0] sel);
    return {24'h0, en, 1'b0, bsy, ovf, 1'b0, sel};
  endfunction
  function automatic int div_of(input logic [2:0] sel);
    case (sel)
      3'd0: return 1;    3'd1: return 4;    3'd2: return 16;  3'd3: return 32;
      3'd4: return 64;   3'd5: return 128;  3'd6: return 1024;
      default: return 4096;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    waitn(3);
    rst_n = 1'b1;
    waitn(1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [15:0] mcnt;
    logic [7:0]  mctlb;
    logic [2:0]  msel;
    void'($urandom(32'd2024));
    bus_addr = '0; bus_wr_en = 1'b0; bus_wdata = '0;
    do_reset();

    // R9 reset state
    rd(4'd0, r); chk("R9 counter", r, 32'h0);
    rd(4'd4, r); chk("R9 ctlA", r, 32'h0);
    rd(4'd8, r); chk("R9 ctlB", r, 32'h0);
    chk("R9 rst_o", {31'h0, wdt_rst_o}, 32'h0);

    // Random writes with timer disabled: R1 R2 R3
    mcnt = 16'h0; mctlb = 8'h0; msel = 3'd0;
    for (int i = 0; i < 40; i++) begin
      int kind;
      logic good;
      logic [31:0] d;
      kind = $urandom_range(0, 2);
      good = $urandom_range(0, 1) == 1;
      d = $urandom();
      if (kind == 0) begin
        if (good) begin d = cnt_word(d[15:0]); mcnt = d[15:0]; end
        else if (d[31:16] == 16'h5A5A) d[31:16] = 16'h5A5B;
        wr(4'd0, d);
        if (!good) begin
          rd(4'd4, r); chk("R3 no busy on bad counter write", {31'h0, r[5]}, 32'h0);
        end
        waitn(3);
        rd(4'd0, r); chk(good ? "R1 counter load" : "R3 bad counter key", r, {16'h0, mcnt});
      end else if (kind == 1) begin
        d[7] = 1'b0;
        if (good) begin d = ctl_word(d[7:0]); msel = d[2:0]; end
        else if (d[31:8] == 24'hA5A5A5) d[31:8] = 24'hA5A5A4;
        wr(4'd4, d);
        waitn(3);
        rd(4'd4, r); chk(good ? "R2 ctlA write" : "R3 bad ctlA key", r, ctla_exp(1'b0, 1'b0, 1'b0, msel));
      end else begin
        if (good) begin d = ctl_word(d[7:0]); mctlb = d[7:0]; end
        else if (d[31:8] == 24'hA5A5A5) d[31:8] = 24'h5A5A5A;
        wr(4'd8, d);
        if (!good) begin
          rd(4'd4, r); chk("R3 no busy on bad ctlB write", {31'h0, r[5]}, 32'h0);
        end
        waitn(3);
        rd(4'd8, r); chk(good ? "R2 ctlB write" : "R3 bad ctlB key", r, {24'h0, mctlb});
      end
    end
    // Counter key on control register must be rejected (R3)
    wr(4'd8, cnt_word(16'h00FF));
    waitn(3);
    rd(4'd8, r); chk("R3 counter key on ctlB", r, {24'h0, mctlb});

    // R8 busy window
    wr(4'd8, ctl_word(8'h3C));
    rd(4'd4, r); chk("R8 busy m0", {31'h0, r[5]}, 32'h1);
    waitn(1); rd(4'd4, r); chk("R8 busy m1", {31'h0, r[5]}, 32'h1);
    waitn(1); rd(4'd4, r); chk("R8 busy m2", {31'h0, r[5]}, 32'h1);
    waitn(1); rd(4'd4, r); chk("R8 busy m3 clear", {31'h0, r[5]}, 32'h0);
    rd(4'd8, r); chk("R2 ctlB readback", r, 32'h3C);

    // R4 prescaler timing for each select
    for (int s = 0; s < 8; s++) begin
      int dv;
      logic [15:0] v;
      dv = div_of(3'(s));
      v = 16'h1000 + 16'($urandom_range(0, 255));
      wr(4'd4, ctl_word({5'b0, 3'(s)}));
      wr(4'd0, cnt_word(v));
      wr(4'd4, ctl_word({5'b10000, 3'(s)}));
      waitn(dv - 1);
      rd(4'd0, r); chk("R4 before first tick", r, {16'h0, v});
      waitn(1);
      rd(4'd0, r); chk("R4 first tick", r, {16'h0, v + 16'd1});
      waitn(2 * dv);
      rd(4'd0, r); chk("R4 third tick", r, {16'h0, v + 16'd3});
    end

    // R5 hold while disabled
    wr(4'd4, ctl_word(8'h00));
    rd(4'd0, r);
    mcnt = r[15:0];
    waitn(50);
    rd(4'd0, r); chk("R5 counter holds", r, {16'h0, mcnt});

    // R6 overflow with divisor 1
    wr(4'd0, cnt_word(16'hFFFD));
    wr(4'd4, ctl_word(8'h80));
    waitn(2);
    rd(4'd0, r); chk("R6 count FFFF", r, 32'h0000FFFF);
    chk("R6 no pulse yet", {31'h0, wdt_rst_o}, 32'h0);
    waitn(1);
    rd(4'd0, r); chk("R6 wrap to zero", r, 32'h0);
    chk("R6 pulse high", {31'h0, wdt_rst_o}, 32'h1);
    rd(4'd4, r); chk("R6 flag set", {31'h0, r[4]}, 32'h1);
    waitn(1);
    chk("R6 pulse one cycle", {31'h0, wdt_rst_o}, 32'h0);
    rd(4'd0, r); chk("R6 counts on after wrap", r, 32'h1);

    // R7 sticky flag
    wr(4'd4, ctl_word(8'h10));
    waitn(3);
    rd(4'd4, r); chk("R7 bit4=1 keeps flag", r, ctla_exp(1'b0, 1'b0, 1'b1, 3'd0));
    wr(4'd4, 32'h12345600);
    waitn(3);
    rd(4'd4, r); chk("R7 bad key keeps flag", r, ctla_exp(1'b0, 1'b0, 1'b1, 3'd0));
    wr(4'd4, ctl_word(8'h00));
    waitn(3);
    rd(4'd4, r); chk("R7 bit4=0 clears flag", r, 32'h0);

    // R10 immediate reset with divisor 16
    wr(4'd4, ctl_word(8'h82));
    wr(4'd0, cnt_word(16'hFFFF));
    waitn(15);
    chk("R10 no pulse before tick", {31'h0, wdt_rst_o}, 32'h0);
    rd(4'd0, r); chk("R10 held at FFFF", r, 32'h0000FFFF);
    waitn(1);
    chk("R10 pulse on first tick", {31'h0, wdt_rst_o}, 32'h1);
    rd(4'd0, r); chk("R10 wrapped", r, 32'h0);

    // R7 and R9: reset input clears flag and control
    do_reset();
    rd(4'd4, r); chk("R7 reset clears flag", r, 32'h0);
    rd(4'd0, r); chk("R9 counter after reset", r, 32'h0);
    rd(4'd8, r); chk("R9 ctlB after reset", r, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule